// File: doc/BRIEF.md
# Low-Frequency 2-D Inverse DCT

This block rebuilds a downscaled picture block from an 8x8 set of transform coefficients in which only a small low-frequency corner carries energy. A general 8-point column transform runs on the three lowest horizontal-frequency columns. The other five columns, and every coefficient outside a fixed low-frequency footprint of eleven positions, count as zero. A light row stage then forms only the few horizontal output samples that a later downsampler keeps.

Coefficients arrive one per accepted beat, 64 beats per block, in column order. While the beats arrive, their contributions build up in an 8x3 bank of column accumulators. Once the block is complete, the row stage emits one reduced row per cycle. Two configuration inputs, sampled with the first beat of each block, choose three or two samples per row and eight or four rows per block.

Top module: `lowfreq_idct`

## Requirements
- R1: After reset, and in every cycle in which out_valid is low, out_valid, out_row and out_pix are all zero.
- R2: Suppose the 64th beat of a block is accepted at clock edge k. Then out_valid is high after edges k+1 to k+N, where N is the row count, with one row per cycle. It is low again after edge k+N+1.
- R3: Beat n of a block, counted from 0, holds horizontal frequency h = n/8 and vertical frequency v = n%8. Coefficients with h >= 3 have no effect on any output.
- R4: Only eleven positions are used: h=0 with v<5, h=1 with v<4, and h=2 with v<2. Every other position is forced to zero.
- R5: The column value for spatial row x and column h is y = (sum over v of K(x,v)*F(h,v) + 2048) >>> 12. Here K(a,b) = round(4096 * c(b)/2 * cos((2a+1)*b*pi/16)), with c(0) = 1/sqrt(2) and c(b) = 1 otherwise. F is the 12-bit two's complement coefficient.
- R6: The sample at horizontal position p of row x is ((sum over h<3 of K(p,h)*y(h,x)) + 2048) >>> 12, saturated to [-256, 255].
- R7: out_pix lane j occupies bits [9j+8 : 9j]. In three-sample mode, lanes 0, 1 and 2 carry positions 0, 3 and 6. In two-sample mode, lanes 0 and 1 carry positions 0 and 4, and lane 2 is zero.
- R8: In eight-row mode, rows 0 to 7 are emitted in order. In four-row mode, rows 0, 2, 4 and 6 are emitted in order. out_row gives the row index.
- R9: cfg_three_pts and cfg_half_rows are used as they stand at the first beat of a block. Changes during the rest of the block have no effect on that block.
- R10: A beat offered while rows are being emitted is not accepted. Cycles with in_valid low do not advance the beat count. The next block may start in the cycle after the last row is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient beat present |
| in_coef | input | 12 | Signed coefficient |
| cfg_three_pts | input | 1 | 1: three samples per row, 0: two |
| cfg_half_rows | input | 1 | 1: four rows per block, 0: eight |
| out_valid | output | 1 | Output row present |
| out_row | output | 3 | Spatial row index of the output row |
| out_pix | output | 27 | Three packed signed 9-bit samples |

## Verification
The block's only latency is fixed: if the last beat is taken at edge k, the first row appears after edge k+1 and each later row one edge after the one before. The bench drives every beat at a falling edge. It counts falling edges from the last beat and compares each row at the falling edge that follows its rising edge. One further edge after the final row, it checks that out_valid has dropped. Blocks that hold in_valid high during emission are followed by a clean block, so a beat taken by mistake would show up there as a wrong sample.

// File: rtl/lfidct_pkg.sv
package lfidct_pkg;

  localparam int NPT     = 8;   // points per 1-D transform
  localparam int NCOL    = 3;   // transformed coefficient columns
  localparam int BASIS_W = 14;  // signed cosine constant width

  typedef enum logic {PH_LOAD, PH_EMIT} phase_t;

  // Q12 basis constant: c(freq)/2 * cos((2*pos+1)*freq*pi/16)
  function automatic logic signed [BASIS_W-1:0] basis_q(input logic [2:0] pos,
                                                        input logic [2:0] freq);
    logic [6:0]  prod;
    logic [4:0]  m;
    logic [4:0]  f;
    logic        neg;
    logic [11:0] mag;
    if (freq == 3'd0) return 14'sd1448;
    prod = {3'b000, pos, 1'b1} * {4'b0000, freq};
    m    = prod[4:0];
    f    = (m > 5'd16) ? (5'd0 - m) : m;
    neg  = (f > 5'd8);
    if (neg) f = 5'd16 - f;
    case (f)
      5'd0:    mag = 12'd2048;
      5'd1:    mag = 12'd2009;
      5'd2:    mag = 12'd1892;
      5'd3:    mag = 12'd1703;
      5'd4:    mag = 12'd1448;
      5'd5:    mag = 12'd1138;
      5'd6:    mag = 12'd784;
      5'd7:    mag = 12'd400;
      default: mag = 12'd0;
    endcase
    return neg ? -$signed({2'b00, mag}) : $signed({2'b00, mag});
  endfunction

  // low-frequency footprint: 5 + 4 + 2 positions
  function automatic logic keep_pos(input logic [2:0] col, input logic [2:0] freq);
    case (col)
      3'd0:    return freq < 3'd5;
      3'd1:    return freq < 3'd4;
      3'd2:    return freq < 3'd2;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lfidct_ctrl.sv
module lfidct_ctrl
  import lfidct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       cfg_three_pts,
  input  logic       cfg_half_rows,
  output logic       take,
  output logic       clear,
  output logic [5:0] beat,
  output logic       emit_busy,
  output logic [2:0] row_idx,
  output logic       three_q,
  output logic       half_q
);

  localparam int BEATS = NPT * NPT;
  localparam logic [5:0] LAST_BEAT = 6'(BEATS - 1);

  phase_t ph;
  logic   last_row;

  assign emit_busy = (ph == PH_EMIT);
  assign take      = in_valid && !emit_busy;
  assign last_row  = emit_busy && (row_idx == (half_q ? 3'd6 : 3'd7));
  assign clear     = last_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_LOAD;
      beat    <= '0;
      row_idx <= '0;
      three_q <= 1'b0;
      half_q  <= 1'b0;
    end else if (emit_busy) begin
      if (last_row) begin
        ph      <= PH_LOAD;
        row_idx <= '0;
      end else begin
        row_idx <= row_idx + (half_q ? 3'd2 : 3'd1);
      end
    end else if (take) begin
      beat <= beat + 6'd1;
      if (beat == 6'd0) begin
        three_q <= cfg_three_pts;
        half_q  <= cfg_half_rows;
      end
      if (beat == LAST_BEAT) begin
        ph      <= PH_EMIT;
        row_idx <= '0;
      end
    end
  end

endmodule

// File: rtl/lfidct_col_bank.sv
module lfidct_col_bank
  import lfidct_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int FRAC   = 12,
  localparam int PROD_W = COEF_W + BASIS_W,
  localparam int ACC_W  = PROD_W + 1,
  localparam int Y_W    = ACC_W - FRAC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic                  clear,
  input  logic [5:0]            beat,
  input  logic [COEF_W-1:0]     coef,
  input  logic [2:0]            rsel,
  output logic [NCOL*Y_W-1:0]   y_flat
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);

  logic [2:0] hcol;
  logic [2:0] vfreq;
  logic       kept;
  logic signed [PROD_W-1:0] coef_x;
  logic signed [PROD_W-1:0] prod [NPT];
  logic signed [ACC_W-1:0]  acc  [NCOL][NPT];

  assign hcol   = beat[5:3];
  assign vfreq  = beat[2:0];
  assign kept   = keep_pos(hcol, vfreq);
  assign coef_x = $signed({{(PROD_W-COEF_W){coef[COEF_W-1]}}, coef});

  for (genvar x = 0; x < NPT; x++) begin : g_mul
    logic signed [BASIS_W-1:0] b;
    assign b       = basis_q(3'(x), vfreq);
    assign prod[x] = $signed({{(PROD_W-BASIS_W){b[BASIS_W-1]}}, b}) * coef_x;
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCOL; c++) begin
      for (int x = 0; x < NPT; x++) begin
        if (!rst_n || clear)
          acc[c][x] <= '0;
        else if (take && kept && (hcol == 3'(c)))
          acc[c][x] <= acc[c][x] + {{(ACC_W-PROD_W){prod[x][PROD_W-1]}}, prod[x]};
      end
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_read
    logic signed [ACC_W-1:0] rnd;
    assign rnd = acc[c][rsel] + HALF;
    assign y_flat[c*Y_W +: Y_W] = rnd[ACC_W-1:FRAC];
  end

endmodule

// File: rtl/lfidct_row_unit.sv
module lfidct_row_unit
  import lfidct_pkg::*;
#(
  parameter int Y_W   = 15,
  parameter int OUT_W = 9,
  parameter int FRAC  = 12,
  localparam int RS_W = Y_W + BASIS_W + 2,
  localparam int Q_W  = RS_W - FRAC
) (
  input  logic [NCOL*Y_W-1:0]  y_flat,
  input  logic                 three_pts,
  output logic [3*OUT_W-1:0]   pix_flat
);

  localparam logic signed [RS_W-1:0] HALF = RS_W'(1) << (FRAC - 1);
  localparam logic signed [Q_W-1:0]  QMAX = Q_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [Q_W-1:0]  QMIN = -Q_W'(1 << (OUT_W - 1));

  for (genvar j = 0; j < 3; j++) begin : g_lane
    logic [2:0]               pos;
    logic                     en;
    logic signed [RS_W-1:0]   sum;
    logic signed [RS_W-1:0]   rnd;
    logic signed [Q_W-1:0]    q;
    logic signed [OUT_W-1:0]  sat;

    assign pos = three_pts ? 3'(3 * j) : 3'((4 * j) % 8);
    assign en  = three_pts || (j < 2);

    always_comb begin
      logic signed [BASIS_W-1:0] b;
      logic [Y_W-1:0]            yv;
      sum = '0;
      for (int h = 0; h < NCOL; h++) begin
        b   = basis_q(pos, 3'(h));
        yv  = y_flat[h*Y_W +: Y_W];
        sum = sum + $signed({{(RS_W-BASIS_W){b[BASIS_W-1]}}, b})
                  * $signed({{(RS_W-Y_W){yv[Y_W-1]}}, yv});
      end
    end

    assign rnd = sum + HALF;
    assign q   = rnd[RS_W-1:FRAC];

    always_comb begin
      if (q > QMAX)      sat = QMAX[OUT_W-1:0];
      else if (q < QMIN) sat = QMIN[OUT_W-1:0];
      else               sat = q[OUT_W-1:0];
    end

    assign pix_flat[j*OUT_W +: OUT_W] = en ? sat : '0;
  end

endmodule

// File: rtl/lowfreq_idct.sv
module lowfreq_idct
  import lfidct_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int OUT_W  = 9,
  parameter int FRAC   = 12,
  localparam int Y_W   = COEF_W + BASIS_W + 1 - FRAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [COEF_W-1:0]    in_coef,
  input  logic                 cfg_three_pts,
  input  logic                 cfg_half_rows,
  output logic                 out_valid,
  output logic [2:0]           out_row,
  output logic [3*OUT_W-1:0]   out_pix
);

  logic                 take;
  logic                 clear;
  logic [5:0]           beat_cnt;
  logic                 emit_busy;
  logic [2:0]           row_idx;
  logic                 three_q;
  logic                 half_q;
  logic [NCOL*Y_W-1:0]  y_flat;
  logic [3*OUT_W-1:0]   pix;

  lfidct_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cfg_three_pts(cfg_three_pts), .cfg_half_rows(cfg_half_rows),
    .take(take), .clear(clear), .beat(beat_cnt), .emit_busy(emit_busy),
    .row_idx(row_idx), .three_q(three_q), .half_q(half_q)
  );

  lfidct_col_bank #(.COEF_W(COEF_W), .FRAC(FRAC)) u_cols (
    .clk(clk), .rst_n(rst_n), .take(take), .clear(clear), .beat(beat_cnt),
    .coef(in_coef), .rsel(row_idx), .y_flat(y_flat)
  );

  lfidct_row_unit #(.Y_W(Y_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_rows (
    .y_flat(y_flat), .three_pts(three_q), .pix_flat(pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_pix   <= '0;
    end else begin
      out_valid <= emit_busy;
      out_row   <= emit_busy ? row_idx : 3'd0;
      out_pix   <= emit_busy ? pix : '0;
    end
  end

endmodule

// File: rtl/lowfreq_idct_chk.sv
module lowfreq_idct_chk #(
  parameter int OUT_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic [2:0]         out_row,
  input logic [3*OUT_W-1:0] out_pix,
  input logic               emit_busy,
  input logic [5:0]         beat_cnt,
  input logic               three_q,
  input logic               half_q
);

  a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_pix == '0 && out_row == 3'd0));

  a_r2_first_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_row == 3'd0);

  a_r2_follows_emit: assert property (@(posedge clk) disable iff (!rst_n)
    emit_busy |=> out_valid);

  a_r8_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> out_row == ($past(out_row) + (half_q ? 3'd2 : 3'd1)));

  a_r8_last_row_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row == (half_q ? 3'd6 : 3'd7)) |=> !out_valid);

  a_r7_lane2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !three_q) |-> out_pix[3*OUT_W-1:2*OUT_W] == '0);

  a_r10_no_beats_in_emit: assert property (@(posedge clk) disable iff (!rst_n)
    emit_busy |-> beat_cnt == 6'd0);

endmodule

bind lowfreq_idct lowfreq_idct_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_row(out_row),
  .out_pix(out_pix), .emit_busy(emit_busy), .beat_cnt(beat_cnt),
  .three_q(three_q), .half_q(half_q)
);

// File: tb/test_lowfreq_idct.sv
module test_lowfreq_idct;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_coef = '0;
  logic        cfg_three_pts = 1'b0;
  logic        cfg_half_rows = 1'b0;
  logic        out_valid;
  logic [2:0]  out_row;
  logic [26:0] out_pix;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  int blk [64];
  bit prev_noisy = 1'b0;

  always #5 clk = ~clk;

  lowfreq_idct i_lowfreq_idct (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
    .cfg_three_pts(cfg_three_pts), .cfg_half_rows(cfg_half_rows),
    .out_valid(out_valid), .out_row(out_row), .out_pix(out_pix)
  );

  task automatic check(input string tag, input longint act, input longint exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // R5 constants restated with real arithmetic
  function automatic longint kq(int a, int b);
    real s, r;
    s = (b == 0) ? 0.5 / $sqrt(2.0) : 0.5;
    r = s * $cos((2 * a + 1) * b * 3.14159265358979 / 16.0) * 4096.0;
    return longint'($rtoi($floor(r + 0.5)));
  endfunction

  function automatic bit kept(int h, int v);   // R4 footprint
    return (h == 0 && v < 5) || (h == 1 && v < 4) || (h == 2 && v < 2);
  endfunction

  function automatic int expect_pix(int x, int p);
    longint y [3];
    longint acc, s, q;
    for (int h = 0; h < 3; h++) begin
      acc = 0;
      for (int v = 0; v < 8; v++)
        if (kept(h, v)) acc += kq(x, v) * longint'(blk[h * 8 + v]);
      y[h] = (acc + 2048) >>> 12;
    end
    s = 0;
    for (int h = 0; h < 3; h++) s += kq(p, h) * y[h];
    q = (s + 2048) >>> 12;
    if (q > 255) q = 255;
    if (q < -256) q = -256;
    return int'(q);
  endfunction

  // send one block; cfg inverted after the first beat (R9)
  task automatic run_block(input string tag, input bit three, input bit half,
                           input bit gaps, input bit noisy);
    int rows;
    string lt;
    for (int n = 0; n < 64; n++) begin
      if (gaps && (n % 5 == 2)) begin
        in_valid = 1'b0;
        in_coef  = 12'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_coef  = 12'(blk[n]);
      cfg_three_pts = (n == 0) ? three : ~three;
      cfg_half_rows = (n == 0) ? half  : ~half;
      @(negedge clk);
    end
    in_valid = noisy;
    in_coef  = 12'($urandom);
    rows = half ? 4 : 8;
    lt = prev_noisy ? "R10" : tag;
    for (int i = 0; i < rows; i++) begin
      int x;
      @(negedge clk);
      in_coef = 12'($urandom);
      x = half ? 2 * i : i;
      check("R2", out_valid, 1, "row valid");
      check("R8 R9", out_row, x, "row index");
      check(lt, $signed(out_pix[8:0]),   expect_pix(x, 0), "lane 0");
      check(lt, $signed(out_pix[17:9]),  expect_pix(x, three ? 3 : 4), "lane 1");
      check(three ? lt : "R7", $signed(out_pix[26:18]), three ? expect_pix(x, 6) : 0, "lane 2");
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", out_valid, 0, "valid after last row");
    prev_noisy = noisy;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid, 0, "reset valid");
    check("R1", out_pix, 0, "reset pix");
    check("R1", out_row, 0, "reset row");

    // impulses at every position of the three transformed columns, all modes (R5, R4)
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int pos = 0; pos < 24; pos++) begin
        for (int n = 0; n < 64; n++) blk[n] = 0;
        blk[pos] = (pos % 2 == 0) ? 700 : -1500;
        run_block(kept(pos / 8, pos % 8) ? "R5" : "R4", cfg[0], cfg[1],
                  pos % 4 == 1, pos % 3 == 0);
      end
    end

    // only columns 3..7 carry data (R3)
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int n = 0; n < 64; n++) blk[n] = (n < 24) ? 0 : int'($signed(12'($urandom)));
      run_block("R3", cfg[0], cfg[1], 1'b0, 1'b0);
    end

    // dense random blocks (R6)
    for (int t = 0; t < 24; t++) begin
      for (int n = 0; n < 64; n++) blk[n] = int'($signed(12'($urandom)));
      run_block("R6", t[0], t[1], t % 3 == 2, t % 4 == 3);
    end

    // saturation corners (R6)
    for (int n = 0; n < 64; n++) blk[n] = 0;
    blk[0] = 2047;
    run_block("R6", 1'b1, 1'b0, 1'b0, 1'b0);
    blk[0] = -2048;
    run_block("R6", 1'b1, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 64; n++) blk[n] = 2047;
    run_block("R6", 1'b1, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 64; n++) blk[n] = -2048;
    run_block("R6", 1'b0, 1'b1, 1'b0, 1'b0);

    report();
  end

endmodule